// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit accumulator, split into an upper word and a lower word, and adds a signed product to it on each operation strobe. In long mode both 32-bit operands are taken as signed numbers and their full 64-bit product is added. In word mode only the lower 16 bits of each operand are used, taken as signed. The new accumulator value can be read on both output words in the cycle after the strobe.

A saturation input selects how results are limited, and the limit depends on the mode. In long mode the whole accumulator is held within a signed 48-bit range. In word mode the lower word is treated as a signed 32-bit accumulator and is clamped at its limits. When that clamp takes effect, the value 1 is written to the upper word as an overflow flag, and the flag stays set through later word-mode operations that do not overflow. With saturation off, both modes wrap modulo 2^64. A clear command zeroes the accumulator and takes priority over a strobe in the same cycle.

Top module: `mac_unit`

## Requirements
- R1: After reset both accumulator words read zero.
- R2: A cycle with `clr` high zeroes both words at the next edge, even when `op_valid` is high in the same cycle.
- R3: With neither `op_valid` nor `clr` high, both words hold their value whatever the operands, mode and saturation inputs do.
- R4: Long mode (`op_word`=0) without saturation sets {hi,lo} to {hi,lo} plus the signed 32x32 product, modulo 2^64. The result is visible in the cycle after the strobe.
- R5: Word mode (`op_word`=1) multiplies bits 15:0 of each operand as signed 16-bit values and ignores bits 31:16. Without saturation the sum wraps modulo 2^64.
- R6: Long mode with saturation clamps the exact sum of the accumulator and the product to the range [-2^47, 2^47-1] and stores it sign-extended to 64 bits. A negative limit gives hi=0xFFFF8000, lo=0, and a positive limit gives hi=0x00007FFF, lo=0xFFFFFFFF.
- R7: Word mode with saturation adds the product to the lower word taken as signed 32-bit. A sum below -2^31 stores lo=0x80000000, a sum above 2^31-1 stores lo=0x7FFFFFFF, and any other sum stores the sum itself.
- R8: In word mode with saturation, an overflow in either direction writes 1 to the upper word. Without an overflow the upper word keeps its previous value, so the flag is sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe: accumulate this cycle |
| op_word | input | 1 | Mode: 0 long (32x32), 1 word (16x16) |
| sat_en | input | 1 | Saturation enable |
| clr | input | 1 | Clear accumulator; has priority over op_valid |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| acc_hi | output | 32 | Accumulator upper word |
| acc_lo | output | 32 | Accumulator lower word |

## Verification
Every pairing of eight corner operands is run from eight different starting accumulators, in all four mode and saturation combinations. The corner operands are zero, ±1, the 32-bit extremes, the 16-bit extremes and a mixed pattern. These runs separate sign extension from zero extension, the 16-bit operand field from the full 32-bit one, and the 48-bit clamp from the 32-bit clamp, and they reach both limits on both sides. A long pseudo-random chain run without clears adds carries across the word boundary and repeated saturation. Directed cases cover clear racing a strobe, idle cycles with changing inputs, a word-mode product that should ignore upper operand bits, and the sticky flag surviving a later in-range word operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic {
        MODE_LONG = 1'b0,
        MODE_WORD = 1'b1
    } mac_mode_e;

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic [WORD_W-1:0]          opnd_a,
    input  logic [WORD_W-1:0]          opnd_b,
    input  mac_mode_e                  mode,
    output logic signed [2*WORD_W-1:0] prod
);
    localparam int ACC_W = 2 * WORD_W;

    logic signed [ACC_W-1:0] mul_a;
    logic signed [ACC_W-1:0] mul_b;

    // Operand selection: word mode looks at the low half only.
    always_comb begin
        if (mode == MODE_WORD) begin
            mul_a = {{(ACC_W-HALF_W){opnd_a[HALF_W-1]}}, opnd_a[HALF_W-1:0]};
            mul_b = {{(ACC_W-HALF_W){opnd_b[HALF_W-1]}}, opnd_b[HALF_W-1:0]};
        end else begin
            mul_a = {{(ACC_W-WORD_W){opnd_a[WORD_W-1]}}, opnd_a};
            mul_b = {{(ACC_W-WORD_W){opnd_b[WORD_W-1]}}, opnd_b};
        end
        prod = mul_a * mul_b;
    end

endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int LONG_SAT_W = 48
) (
    input  logic [WORD_W-1:0]          acc_hi,
    input  logic [WORD_W-1:0]          acc_lo,
    input  logic signed [2*WORD_W-1:0] prod,
    input  mac_mode_e                  mode,
    input  logic                       sat_en,
    output logic [WORD_W-1:0]          nxt_hi,
    output logic [WORD_W-1:0]          nxt_lo,
    output logic                       word_ovf
);
    localparam int ACC_W = 2 * WORD_W;
    localparam int SUM_W = ACC_W + 2;

    localparam logic signed [SUM_W-1:0] LONG_MAX =
        {{(SUM_W-LONG_SAT_W+1){1'b0}}, {(LONG_SAT_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LONG_MIN =
        {{(SUM_W-LONG_SAT_W+1){1'b1}}, {(LONG_SAT_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] WORD_MAX =
        {{(SUM_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] WORD_MIN =
        {{(SUM_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] FLAG_ONE = WORD_W'(1);

    logic [ACC_W-1:0]        wrap_sum;
    logic signed [SUM_W-1:0] prod_x;
    logic signed [SUM_W-1:0] long_sum;
    logic signed [SUM_W-1:0] word_sum;
    logic [ACC_W-1:0]        long_res;

    always_comb begin
        prod_x   = {{2{prod[ACC_W-1]}}, prod};
        wrap_sum = {acc_hi, acc_lo} + prod;
        long_sum = {{2{acc_hi[WORD_W-1]}}, acc_hi, acc_lo} + prod_x;
        word_sum = {{(SUM_W-WORD_W){acc_lo[WORD_W-1]}}, acc_lo} + prod_x;

        // Long-mode clamp to the signed 48-bit window.
        if (long_sum > LONG_MAX) begin
            long_res = LONG_MAX[ACC_W-1:0];
        end else if (long_sum < LONG_MIN) begin
            long_res = LONG_MIN[ACC_W-1:0];
        end else begin
            long_res = long_sum[ACC_W-1:0];
        end

        {nxt_hi, nxt_lo} = wrap_sum;
        word_ovf         = 1'b0;

        if (sat_en) begin
            if (mode == MODE_LONG) begin
                {nxt_hi, nxt_lo} = long_res;
            end else if (word_sum > WORD_MAX) begin
                nxt_hi   = FLAG_ONE;
                nxt_lo   = WORD_MAX[WORD_W-1:0];
                word_ovf = 1'b1;
            end else if (word_sum < WORD_MIN) begin
                nxt_hi   = FLAG_ONE;
                nxt_lo   = WORD_MIN[WORD_W-1:0];
                word_ovf = 1'b1;
            end else begin
                nxt_hi = acc_hi;
                nxt_lo = word_sum[WORD_W-1:0];
            end
        end
    end

    // R8: the overflow flag only arises in saturating word mode
    always_comb begin
        if (word_ovf) begin
            assert (sat_en && mode == MODE_WORD)
                else $error("p_ovf_only_word_sat_r8");
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int HALF_W     = 16,
    parameter int LONG_SAT_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_word,
    input  logic              sat_en,
    input  logic              clr,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic [WORD_W-1:0] acc_hi,
    output logic [WORD_W-1:0] acc_lo
);
    localparam int ACC_W       = 2 * WORD_W;
    localparam int SIGN_HI_LSB = LONG_SAT_W - 1 - WORD_W;
    localparam int SIGN_HI_W   = WORD_W - SIGN_HI_LSB;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } acc_t;

    acc_t                    st_d, st_q;
    mac_mode_e               mode;
    logic signed [ACC_W-1:0] prod;
    logic [WORD_W-1:0]       nxt_hi;
    logic [WORD_W-1:0]       nxt_lo;
    logic                    word_ovf;

    assign mode = mac_mode_e'(op_word);

    mac_product #(
        .WORD_W (WORD_W),
        .HALF_W (HALF_W)
    ) u_product (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .mode   (mode),
        .prod   (prod)
    );

    mac_saturate #(
        .WORD_W     (WORD_W),
        .LONG_SAT_W (LONG_SAT_W)
    ) u_saturate (
        .acc_hi   (st_q.hi),
        .acc_lo   (st_q.lo),
        .prod     (prod),
        .mode     (mode),
        .sat_en   (sat_en),
        .nxt_hi   (nxt_hi),
        .nxt_lo   (nxt_lo),
        .word_ovf (word_ovf)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (op_valid) begin
            st_d.hi = nxt_hi;
            st_d.lo = nxt_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_hi = st_q.hi;
    assign acc_lo = st_q.lo;

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0 && acc_lo == '0));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !op_valid) |=> ($stable(acc_hi) && $stable(acc_lo)));

    p_long_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && sat_en && !op_word) |=>
        (acc_hi[WORD_W-1:SIGN_HI_LSB] == '0 ||
         acc_hi[WORD_W-1:SIGN_HI_LSB] == {SIGN_HI_W{1'b1}}));

    p_word_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && word_ovf) |=>
        (acc_lo == {1'b0, {(WORD_W-1){1'b1}}} ||
         acc_lo == {1'b1, {(WORD_W-1){1'b0}}}));

    p_word_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && word_ovf) |=> (acc_hi == WORD_W'(1)));

    p_word_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && sat_en && op_word && acc_hi == WORD_W'(1)) |=>
        (acc_hi == WORD_W'(1)));

endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_word, sat_en, clr;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] acc_hi, acc_lo;

    int n_checks = 0;
    int n_errors = 0;
    logic [63:0] mdl;

    always #2 clk = ~clk;

    mac_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_word  (op_word),
        .sat_en   (sat_en),
        .clr      (clr),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .acc_hi   (acc_hi),
        .acc_lo   (acc_lo)
    );

    localparam logic signed [65:0] L_MAX = 66'sh0_0000_7FFF_FFFF_FFFF;
    localparam logic signed [65:0] L_MIN = 66'sh3_FFFF_8000_0000_0000;
    localparam logic signed [65:0] W_MAX = 66'sh0_0000_0000_7FFF_FFFF;
    localparam logic signed [65:0] W_MIN = 66'sh3_FFFF_FFFF_8000_0000;

    function automatic logic [31:0] corner(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h0000_7FFF;
            6: return 32'hFFFF_8000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [63:0] ref_next(logic [63:0] acc, logic [31:0] a,
                                            logic [31:0] b, logic w, logic s);
        logic signed [65:0] pa, pb, pr, sum;
        if (w) begin
            pa = {{50{a[15]}}, a[15:0]};
            pb = {{50{b[15]}}, b[15:0]};
        end else begin
            pa = {{34{a[31]}}, a};
            pb = {{34{b[31]}}, b};
        end
        pr = pa * pb;
        if (!s) return acc + pr[63:0];
        if (!w) begin
            sum = {{2{acc[63]}}, acc} + pr;
            if (sum > L_MAX) return L_MAX[63:0];
            if (sum < L_MIN) return L_MIN[63:0];
            return sum[63:0];
        end
        sum = {{34{acc[31]}}, acc[31:0]} + pr;
        if (sum > W_MAX) return {32'd1, 32'h7FFF_FFFF};
        if (sum < W_MIN) return {32'd1, 32'h8000_0000};
        return {acc[63:32], sum[31:0]};
    endfunction

    task automatic check(string tag, logic [63:0] exp);
        n_checks++;
        if ({acc_hi, acc_lo} !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h_%h expected %h_%h", tag, acc_hi, acc_lo,
                     exp[63:32], exp[31:0]);
        end
    endtask

    task automatic do_op(logic [31:0] a, logic [31:0] b, logic w, logic s);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_word = w; sat_en = s; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        mdl = ref_next(mdl, a, b, w, s);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        mdl = '0;
    endtask

    initial begin
        #(4 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_word = 1'b0; sat_en = 1'b0; clr = 1'b0;
        opnd_a = '0; opnd_b = '0; mdl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", 64'd0);

        // Corner sweep: preset accumulator, then one tested operation
        for (int p = 0; p < 8; p++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    for (int m = 0; m < 4; m++) begin
                        do_clear();
                        do_op(corner(p), corner(7 - p) ^ 32'h0000_0100, 1'b0, 1'b0);
                        do_op(corner(ia), corner(ib), m[0], m[1]);
                        case (m)
                            0: check("R4 long wrap sweep", mdl);
                            1: check("R5 word wrap sweep", mdl);
                            2: check("R6 long clamp sweep", mdl);
                            default: check("R7 R8 word clamp sweep", mdl);
                        endcase
                    end
                end
            end
        end

        // R6 explicit limits
        do_clear();
        do_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1);
        check("R6 positive limit", 64'h0000_7FFF_FFFF_FFFF);
        do_clear();
        do_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1);
        check("R6 negative limit", 64'hFFFF_8000_0000_0000);

        // R5 upper operand bits ignored in word mode
        do_clear();
        do_op(32'hABCD_0003, 32'h5555_FFFE, 1'b1, 1'b0);
        check("R5 upper bits ignored", 64'hFFFF_FFFF_FFFF_FFFA);

        // R8 sticky flag across an in-range word operation
        do_clear();
        do_op(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);
        do_op(32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1);
        check("R8 flag set on overflow", {32'd1, 32'h7FFF_FFFF});
        do_op(32'h0000_0002, 32'hFFFF_FFFD, 1'b1, 1'b1);
        check("R8 flag sticky", {32'd1, 32'h7FFF_FFF9});

        // R2 clear wins over a simultaneous strobe
        do_op(32'h1234_5678, 32'h0000_0100, 1'b0, 1'b0);
        @(negedge clk);
        clr = 1'b1; op_valid = 1'b1;
        @(negedge clk);
        clr = 1'b0; op_valid = 1'b0; mdl = '0;
        check("R2 clear priority", 64'd0);

        // R3 idle hold with moving inputs
        do_op(32'h0000_1234, 32'hFFFF_0011, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            opnd_a = 32'hDEAD_0000 + k; opnd_b = 32'h0BAD_F00D; op_word = k[0]; sat_en = k[1];
        end
        @(negedge clk);
        check("R3 idle hold", mdl);

        // Pseudo-random chain without clears
        begin
            logic [31:0] lcg;
            lcg = 32'h1F2E_3D4C;
            do_clear();
            for (int k = 0; k < 400; k++) begin
                logic [31:0] ra, rb;
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                ra = lcg;
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                rb = lcg;
                do_op(ra, rb, lcg[7], lcg[13]);
                check("R4 R5 R6 R7 R8 random chain", mdl);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule